// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block serialises 8-bit or 9-bit characters onto a single transmit line. Each character has a low start bit, the payload sent least-significant bit first, and a high stop bit. Software writes a character into a one-entry holding register. As soon as the shift register is free, the character moves into it and the holding register is free to take the next one. The ninth bit is supplied by the writer with each character. The block does no parity computation.

A break request can be armed ahead of a write. The next character written is then sent as a break: a start bit, twelve zero bits and a stop bit. The written payload is discarded. The request flag stays visible until that break has left the line, and hardware then clears it. This suits the header of a LIN-style bus frame. Bit timing comes from an external one-cycle tick: each bit is held on the line until a tick ends it. Dropping the enable aborts any frame in progress and empties both registers.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, tx_line is 1, hold_empty_irq is 1, shift_empty is 1 and brk_pending is 0.
- R2: When idle, tx_line is 1. A frame is a 0 start bit, then the payload LSB first, then a 1 stop bit.
- R3: With nine_sel=0 the payload is the 8 bits of wr_data. With nine_sel=1 the payload is wr_data followed by wr_bit9 as a ninth bit. nine_sel is taken when the character enters the shift register.
- R4: A write made while tx_en=0 is ignored: hold_empty_irq stays 1 and nothing is sent.
- R5: A write is accepted only in a cycle where hold_empty_irq=1. A write while the holding register is full is ignored and its character is never sent.
- R6: When the holding register is full and the shift register is empty, the character moves across at the next clock edge. After that edge, hold_empty_irq=1, shift_empty=0 and tx_line=0.
- R7: A pulse on brk_req_set arms a break. The first character accepted afterwards is sent as 0, twelve 0s, then 1, and its data is ignored. The following character is sent normally.
- R8: brk_pending reads 1 from the cycle after brk_req_set until the armed break frame has been sent, and 0 after that.
- R9: Driving tx_en to 0 while a frame is in progress returns tx_line to 1 and sets hold_empty_irq=1 and shift_empty=1 after the next clock edge.
- R10: A bit stays on tx_line until a cycle with bit_tick=1. A tick while the shift register is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low aborts and empties |
| nine_sel | input | 1 | 1 selects 9-bit payload |
| brk_req_set | input | 1 | Pulse arming a break on the next character |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character payload |
| wr_bit9 | input | 1 | Ninth payload bit |
| bit_tick | input | 1 | One-cycle pulse ending the current bit |
| tx_line | output | 1 | Serial output, idle high |
| hold_empty_irq | output | 1 | Holding register can accept a write |
| shift_empty | output | 1 | Shift register holds no frame |
| brk_pending | output | 1 | Break armed or being sent |

## Verification
The bench uses the default parameters, DATA_W=8 and BRK_ZEROS=12. With these, the 14-bit break frame is longer than the 11-bit frame of a 9-bit character, so the shift register is sized by the break path and both frame lengths get exercised. Tick spacing is randomised between 3 and 6 cycles. This places writes and transfers at different points within a bit, and it brings same-cycle write/transfer collisions and back-to-back frames within reach.

// File: rtl/uart_brk_pkg.sv
// Shared types for the break-capable serial transmitter.
// Assumes: nothing beyond standard SystemVerilog.
package uart_brk_pkg;
    // Kind of frame loaded into the shift register
    typedef enum logic [1:0] {
        FRM_8   = 2'd0,
        FRM_9   = 2'd1,
        FRM_BRK = 2'd2
    } frame_kind_e;
endpackage

// File: rtl/uart_hold_reg.sv
// One-entry holding register in front of the shifter.
// Accepts a write only while empty and enabled; emptied by a take or by disable.
// Assumes: take is only asserted while full.
module uart_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              wr_brk,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data_q,
    output logic              bit9_q,
    output logic              brk_q
);
    // Occupancy and contents of the holding slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            data_q <= '0;
            bit9_q <= 1'b0;
            brk_q  <= 1'b0;
        end else if (!tx_en) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full   <= 1'b1;
            data_q <= wr_data;
            bit9_q <= wr_bit9;
            brk_q  <= wr_brk;
        end
    end

    // A write into a full slot must not disturb its contents
    assert_full_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && full && !take && tx_en) |=> ($stable(data_q) && $stable(bit9_q) && full));
endmodule

// File: rtl/uart_tx_shifter.sv
// Frame shift register: builds start/payload/stop or a break frame on load,
// then shifts one bit per tick, LSB first.
// Assumes: load is only asserted while not busy.
module uart_tx_shifter
    import uart_brk_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BRK_ZEROS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              load,
    input  frame_kind_e       kind,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    input  logic              tick,
    output logic              busy,
    output logic              tx,
    output logic              brk_done
);
    localparam int NORM_W  = DATA_W + 3;
    localparam int BRK_W   = BRK_ZEROS + 2;
    localparam int FRAME_W = (NORM_W > BRK_W) ? NORM_W : BRK_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh;
    logic [FRAME_W-1:0] ld_vec;
    logic [CNT_W-1:0]   left;
    logic [CNT_W-1:0]   ld_len;
    logic               cur_brk;

    // Build the frame image and its length for the kind being loaded
    always_comb begin
        ld_vec = '1;
        ld_len = '0;
        case (kind)
            FRM_8: begin
                ld_vec[0]        = 1'b0;
                ld_vec[DATA_W:1] = data;
                ld_len           = CNT_W'(DATA_W + 2);
            end
            FRM_9: begin
                ld_vec[0]          = 1'b0;
                ld_vec[DATA_W:1]   = data;
                ld_vec[DATA_W+1]   = bit9;
                ld_len             = CNT_W'(DATA_W + 3);
            end
            FRM_BRK: begin
                ld_vec[BRK_W-2:0] = '0;
                ld_len            = CNT_W'(BRK_W);
            end
            default: begin
                ld_vec = '1;
                ld_len = '0;
            end
        endcase
    end

    // Load, shift and abort of the frame in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sh      <= '1;
            left    <= '0;
            cur_brk <= 1'b0;
        end else if (!tx_en) begin
            busy    <= 1'b0;
            cur_brk <= 1'b0;
        end else if (load) begin
            busy    <= (ld_len != '0);
            sh      <= ld_vec;
            left    <= ld_len;
            cur_brk <= (kind == FRM_BRK);
        end else if (busy && tick) begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - 1'b1;
            if (left == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign tx       = busy ? sh[0] : 1'b1;
    assign brk_done = busy && tick && tx_en && cur_brk && (left == CNT_W'(1));

    // Every frame opens with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tx_en) |=> (busy && tx == 1'b0));
    // Line is held between ticks
    assert_bit_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && tx_en) |=> $stable(tx));
    // A break keeps the line low until its stop bit
    assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_brk && left > CNT_W'(1)) |-> (tx == 1'b0));
endmodule

// File: rtl/uart_brk_tx.sv
// Top: asynchronous transmitter with one-entry holding register,
// 8/9-bit payloads and an armed, self-clearing break request.
// Assumes: bit_tick is a one-cycle pulse from an external rate generator.
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BRK_ZEROS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              nine_sel,
    input  logic              brk_req_set,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              bit_tick,
    output logic              tx_line,
    output logic              hold_empty_irq,
    output logic              shift_empty,
    output logic              brk_pending
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_bit9;
    logic              hold_brk;
    logic              sh_busy;
    logic              brk_done;
    logic              brk_used;
    logic              wr_take;
    logic              xfer;
    frame_kind_e       kind;

    assign wr_take = wr_stb && tx_en && !hold_full;
    assign xfer    = hold_full && !sh_busy && tx_en;
    assign kind    = hold_brk ? FRM_BRK : (nine_sel ? FRM_9 : FRM_8);

    uart_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .wr_bit9 (wr_bit9),
        .wr_brk  (brk_pending && !brk_used),
        .take    (xfer),
        .full    (hold_full),
        .data_q  (hold_data),
        .bit9_q  (hold_bit9),
        .brk_q   (hold_brk)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .load     (xfer),
        .kind     (kind),
        .data     (hold_data),
        .bit9     (hold_bit9),
        .tick     (bit_tick),
        .busy     (sh_busy),
        .tx       (tx_line),
        .brk_done (brk_done)
    );

    // Break request flag: set by software, cleared when the break leaves the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_pending <= 1'b0;
        end else if (brk_req_set) begin
            brk_pending <= 1'b1;
        end else if (brk_done) begin
            brk_pending <= 1'b0;
        end
    end

    // Marks that the armed break has been bound to an accepted character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_used <= 1'b0;
        end else if (!tx_en || brk_done) begin
            brk_used <= 1'b0;
        end else if (wr_take && brk_pending) begin
            brk_used <= 1'b1;
        end
    end

    assign hold_empty_irq = !hold_full;
    assign shift_empty    = !sh_busy;

    assert_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !sh_busy && tx_en) |=> (sh_busy && !hold_full));
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en) |=> (!hold_full && !sh_busy && tx_line));
    assert_brk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pending && !brk_done) |=> brk_pending);
    assert_disabled_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !tx_en) |=> !hold_full);
endmodule

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       nine_sel = 1'b0;
    logic       brk_req_set = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bit9 = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_line, hold_empty_irq, shift_empty, brk_pending;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  tick_cnt = 3;
    bit  mon_on = 1'b0;
    bit  m_pend = 1'b0;
    bit  m_used = 1'b0;
    bit  exp_q[$];

    always #10 clk = ~clk;

    uart_brk_tx dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nine_sel(nine_sel),
        .brk_req_set(brk_req_set), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_bit9(wr_bit9), .bit_tick(bit_tick), .tx_line(tx_line),
        .hold_empty_irq(hold_empty_irq), .shift_empty(shift_empty),
        .brk_pending(brk_pending)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Expected line bits for one frame; kind 0=8-bit, 1=9-bit, 2=break
    task automatic push_frame(input logic [7:0] d, input bit b9, input int kind);
        exp_q.push_back(1'b0);
        if (kind == 2) begin
            for (int i = 0; i < 12; i++) exp_q.push_back(1'b0);
        end else begin
            for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
            if (kind == 1) exp_q.push_back(b9);
        end
        exp_q.push_back(1'b1);
    endtask

    // Tick generator, line monitor and watchdog (all at the falling edge)
    always @(negedge clk) begin
        cyc++;
        if (tick_cnt == 0) begin
            bit_tick = 1'b1;
            tick_cnt = 2 + $urandom_range(0, 3);
        end else begin
            bit_tick = 1'b0;
            tick_cnt--;
        end
        if (bit_tick && mon_on && !shift_empty && rst_n) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4/R5 unexpected frame bit", int'(tx_line), -1);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(tx_line == e, "R2/R3/R7 line bit", int'(tx_line), int'(e));
            end
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    // One write strobe; the model decides acceptance from the visible state
    task automatic drive_write(input logic [7:0] d, input bit b9);
        wr_stb = 1'b1; wr_data = d; wr_bit9 = b9;
        if (hold_empty_irq && tx_en) begin
            if (m_pend && !m_used) begin
                m_used = 1'b1;
                push_frame(d, b9, 2);
            end else begin
                push_frame(d, b9, nine_sel ? 1 : 0);
            end
        end
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input bit b9);
        while (!hold_empty_irq) @(negedge clk);
        drive_write(d, b9);
    endtask

    task automatic wait_idle(input string req);
        while (!(hold_empty_irq && shift_empty)) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1'b1, "R1 tx_line", tx_line, 1);
        chk(hold_empty_irq == 1'b1, "R1 hold_empty_irq", hold_empty_irq, 1);
        chk(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);
        chk(brk_pending == 1'b0, "R1 brk_pending", brk_pending, 0);
        mon_on = 1'b1;

        // R4: write while disabled is ignored
        drive_write(8'hA5, 1'b0);
        chk(hold_empty_irq == 1'b1, "R4 hold after disabled write", hold_empty_irq, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_line != 1'b1) chk(1'b0, "R4 line stays idle", tx_line, 1);
        end
        chk(shift_empty == 1'b1, "R4/R10 shifter idle despite ticks", shift_empty, 1);

        // R6: transfer timing from an idle shifter
        tx_en = 1'b1;
        @(negedge clk);
        drive_write(8'h3C, 1'b0);
        chk(hold_empty_irq == 1'b0, "R6 holding full after write", hold_empty_irq, 0);
        @(negedge clk);
        chk(hold_empty_irq == 1'b1, "R6 holding freed by transfer", hold_empty_irq, 1);
        chk(shift_empty == 1'b0, "R6 shifter loaded", shift_empty, 0);
        chk(tx_line == 1'b0, "R6 start bit on line", tx_line, 0);
        wait_idle("R6 frame complete");

        // R5: consecutive writes; the one hitting a full slot is dropped
        drive_write(8'h11, 1'b0);
        drive_write(8'h22, 1'b0);
        drive_write(8'h33, 1'b0);
        chk(hold_empty_irq == 1'b0, "R5 slot full after third write", hold_empty_irq, 0);
        drive_write(8'h44, 1'b0);
        chk(shift_empty == 1'b0, "R6 shifter busy", shift_empty, 0);
        wait_idle("R5 only accepted characters sent");

        // R7/R8: armed break then a normal character
        brk_req_set = 1'b1;
        @(negedge clk);
        brk_req_set = 1'b0;
        m_pend = 1'b1;
        chk(brk_pending == 1'b1, "R8 pending after request", brk_pending, 1);
        send(8'hFF, 1'b1);
        send(8'h55, 1'b0);
        repeat (30) @(negedge clk);
        chk(brk_pending == 1'b1, "R8 pending during break", brk_pending, 1);
        wait_idle("R7 break then data sent");
        chk(brk_pending == 1'b0, "R8 cleared after break", brk_pending, 0);
        m_pend = 1'b0; m_used = 1'b0;

        // R3: random 8-bit then 9-bit characters
        for (int mode = 0; mode < 2; mode++) begin
            nine_sel = (mode == 1);
            for (int k = 0; k < 25; k++) begin
                send(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
                repeat ($urandom_range(0, 3)) @(negedge clk);
            end
            wait_idle("R3 random stream drained");
        end
        nine_sel = 1'b0;

        // R9: abort mid-frame with a character waiting
        mon_on = 1'b0;
        send(8'h0F, 1'b0);
        send(8'hF0, 1'b0);
        repeat (15) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R9 line idle after abort", tx_line, 1);
        chk(shift_empty == 1'b1, "R9 shifter emptied", shift_empty, 1);
        chk(hold_empty_irq == 1'b1, "R9 holding emptied", hold_empty_irq, 1);
        exp_q.delete();
        repeat (10) @(negedge clk);
        chk(tx_line == 1'b1, "R9 line stays idle", tx_line, 1);
        tx_en = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        send(8'h96, 1'b0);
        wait_idle("R9 recovery frame");

        summary();
        $finish;
    end
endmodule